// File: doc/BRIEF.md
# Masked Pin-Change and External Interrupt Controller

This block watches sixteen general-purpose pins and one dedicated interrupt pin, and raises three interrupt requests toward a CPU. The sixteen pins are split into two groups of eight. Each group has a mask register, and any unmasked pin in a group that toggles in either direction raises that group's request. The dedicated pin has a two-bit sense mode: low level, any change, falling edge or rising edge. Edge and toggle events are held in sticky flags. In low-level mode the request follows the pin directly and no flag is stored.

Every pin passes through a two-flop synchroniser, and edges are found by comparing each synchronised value with its value one cycle earlier. Detection uses only the pin value and ignores the pin's direction, so software that drives a pin as an output can use it to raise an interrupt. The CPU sets up the block through a small write port. It clears a flag either with a one-cycle acknowledge pulse on that source's line or by writing a one to the flag's bit in the clear register.

Top module: `pcx_irq_ctrl`

## Requirements
- R1: Reset clears all masks, enables and flags, and drives `irq_o` and `flags_o` to zero. No flag is set after reset because of pin levels that were already present when reset was released.
- R2: Source index 1 (group 0) sets flag bit 1 when any pin among `pin_i[7:0]` whose mask-0 bit is set toggles, rising or falling.
- R3: Source index 2 (group 1) sets flag bit 2 when any pin among `pin_i[15:8]` whose mask-1 bit is set toggles. Pin 8+i uses mask-1 bit i.
- R4: A pin whose mask bit is 0 has no effect on its group. Setting a mask bit while the pin sits at a steady level does not set the flag.
- R5: With sense 00 (low level), `irq_o[0]` is high whenever the enable for source 0 is set and the synchronised `xint_i` is low. It drops when the pin returns high, and flag bit 0 is never set in this mode.
- R6: Sense 10 sets flag bit 0 on falling edges of `xint_i` only. Sense 11 sets it on rising edges only. Sense 01 sets it on both edges.
- R7: A flag stays set until it is cleared. It clears on a one-cycle `ack_i[k]` pulse, or on a write to address 3 with data bit k set. Each request bit equals its flag ANDed with its enable. A flag sets even while its enable is 0, and raises the request as soon as the enable is set.
- R8: When a new event and a clear reach the same flag in the same cycle, the flag stays set.
- R9: A pin change sampled at one clock edge sets its flag, and shows on `irq_o`, three clock edges later. In level mode the request follows the pin two edges later.
- R10: The write port decodes addresses as follows. Address 0 is control: bits [1:0] are the sense mode, bit 2 enables source 0, bit 3 enables source 1 and bit 4 enables source 2. Address 1 is mask 0, address 2 is mask 1, and address 3 is write-1-to-clear for flag bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 16 | General-purpose pin levels, two groups of eight |
| xint_i | input | 1 | Dedicated interrupt pin |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 2 | Configuration register address |
| wr_data_i | input | 8 | Configuration write data |
| ack_i | input | 3 | One-cycle acknowledge per source (0 dedicated, 1 group 0, 2 group 1) |
| irq_o | output | 3 | Interrupt requests per source |
| flags_o | output | 3 | Sticky event flags per source |

## Verification
The bench targets a mask bit being set while its pin is already high. A design that let the previous-value register follow only masked pins would raise a false group event here. It also releases reset with pins already high and sets the masks at once. A design that compared against a zero-reset history would latch a false flag. An acknowledge is made to coincide with a fresh toggle; a design where clear beats set would lose that interrupt. Each sense mode is driven through both edges, which exposes a swapped polarity or a level mode that latches a flag.

// File: rtl/pcx_irq_pkg.sv
package pcx_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned NUM_SRC = NUM_GRP + 1;
  localparam int unsigned SRC_EXT = 0;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CTRL_W  = 2 + NUM_SRC;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd3;
  localparam logic [1:0] WARM_DONE = 2'd3;
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/pcx_grp_detect.sv
module pcx_grp_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  output logic         evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  // history follows every pin, masked or not
  always_comb prev_d = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign evt = arm & (|((cur ^ prev_q) & mask));
endmodule

// File: rtl/pcx_xsense.sv
module pcx_xsense
  import pcx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       cur,
  input  logic [1:0] sense,
  output logic       evt,
  output logic       lvl
);
  logic prev_q;
  logic rise;
  logic fall;
  logic evt_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    case (sense)
      SNS_ANY:  evt_raw = rise | fall;
      SNS_FALL: evt_raw = fall;
      SNS_RISE: evt_raw = rise;
      default:  evt_raw = 1'b0;
    endcase
  end

  assign evt = arm & evt_raw;
  assign lvl = (sense == SNS_LOW) & ~cur;
endmodule

// File: rtl/pcx_flag.sv
module pcx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic flag_q;
  logic flag_d;

  // a fresh event outranks a clear in the same cycle
  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign q = flag_q;
endmodule

// File: rtl/pcx_irq_ctrl.sv
module pcx_irq_ctrl
  import pcx_irq_pkg::*;
#(
  parameter int unsigned GRP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [GRP_W*NUM_GRP-1:0]      pin_i,
  input  logic                          xint_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [GRP_W-1:0]              wr_data_i,
  input  logic [NUM_SRC-1:0]            ack_i,
  output logic [NUM_SRC-1:0]            irq_o,
  output logic [NUM_SRC-1:0]            flags_o
);
  localparam int unsigned PIN_W = GRP_W * NUM_GRP;

  logic [PIN_W-1:0]                pin_sync;
  logic                            x_sync;
  logic [1:0]                      warm_q, warm_d;
  logic                            armed;
  logic [1:0]                      sense_q, sense_d;
  logic [NUM_SRC-1:0]              en_q, en_d;
  logic [NUM_GRP-1:0][GRP_W-1:0]   mask_q, mask_d;
  logic [NUM_GRP-1:0]              grp_evt;
  logic                            x_evt;
  logic                            x_lvl;
  logic [NUM_SRC-1:0]              evt_vec;
  logic [NUM_SRC-1:0]              clr_vec;
  logic [NUM_SRC-1:0]              flag_q;
  logic                            wr_clr;
  logic                            unused_wdata;

  assign unused_wdata = ^wr_data_i[GRP_W-1:CTRL_W];

  pcx_sync #(.W(PIN_W)) u_pin_sync (.clk(clk), .rst_n(rst_n), .d(pin_i),  .q(pin_sync));
  pcx_sync #(.W(1))     u_x_sync   (.clk(clk), .rst_n(rst_n), .d(xint_i), .q(x_sync));

  // warm-up: events stay gated until the history holds synchronised pins
  always_comb begin
    warm_d = warm_q;
    if (warm_q != WARM_DONE) warm_d = warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else        warm_q <= warm_d;
  end

  assign armed = (warm_q == WARM_DONE);

  // configuration registers
  always_comb begin
    sense_d = sense_q;
    en_d    = en_q;
    mask_d  = mask_q;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_CTRL) begin
        sense_d = wr_data_i[1:0];
        en_d    = wr_data_i[CTRL_W-1:2];
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (wr_addr_i == ADDR_W'(g + 1)) mask_d[g] = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= 2'b00;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      sense_q <= sense_d;
      en_q    <= en_d;
      mask_q  <= mask_d;
    end
  end

  // detectors
  pcx_xsense u_xsense (
    .clk(clk), .rst_n(rst_n), .arm(armed), .cur(x_sync),
    .sense(sense_q), .evt(x_evt), .lvl(x_lvl)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pcx_grp_detect #(.W(GRP_W)) u_det (
      .clk(clk), .rst_n(rst_n), .arm(armed),
      .cur(pin_sync[g*GRP_W +: GRP_W]), .mask(mask_q[g]), .evt(grp_evt[g])
    );
  end

  assign evt_vec = {grp_evt, x_evt};
  assign wr_clr  = wr_en_i & (wr_addr_i == ADDR_CLR);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign clr_vec[k] = ack_i[k] | (wr_clr & wr_data_i[k]);
    pcx_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(evt_vec[k]), .clr(clr_vec[k]), .q(flag_q[k])
    );
    if (k == SRC_EXT) begin : g_ext
      assign irq_o[k] = en_q[k] & (flag_q[k] | x_lvl);
    end else begin : g_pc
      assign irq_o[k] = en_q[k] & flag_q[k];
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/pcx_irq_ctrl_chk.sv
module pcx_irq_ctrl_chk #(
  parameter int unsigned GRP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       irq,
  input logic [2:0]       flags,
  input logic [2:0]       ack,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [GRP_W-1:0] wr_data,
  input logic [1:0]       sense,
  input logic [2:0]       en,
  input logic             xcur,
  input logic [1:0]       gevt,
  input logic [GRP_W-1:0] mask0
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (flags == 3'b000 && irq == 3'b000)
        else $error("reset state not clear");
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_k
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[k]) |-> $past(ack[k] | (wr_en && wr_addr == 2'd3 && wr_data[k])))
      else $error("flag dropped without a clear");
  end

  p_set_wins_g0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gevt[0] |=> flags[1]) else $error("group 0 event lost");

  p_set_wins_g1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gevt[1] |=> flags[2]) else $error("group 1 event lost");

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(|mask0)) else $error("flag with empty mask");

  p_level_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(sense) != 2'b00)) else $error("flag latched in level mode");

  p_level_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == 2'b00 && en[0] && !xcur) |-> irq[0]) else $error("level request missing");

  p_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) && $past(sense) == 2'b10) |-> !$past(xcur))
    else $error("falling mode took a rise");

  p_rise_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) && $past(sense) == 2'b11) |-> $past(xcur))
    else $error("rising mode took a fall");
endmodule

bind pcx_irq_ctrl pcx_irq_ctrl_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .flags(flags_o), .ack(ack_i),
  .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
  .sense(sense_q), .en(en_q), .xcur(x_sync), .gevt(grp_evt), .mask0(mask_q[0])
);

// File: tb/pcx_irq_ctrl_test.sv
`timescale 1ns/1ps
module pcx_irq_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] pin_i;
  logic        xint_i;
  logic        wr_en_i;
  logic [1:0]  wr_addr_i;
  logic [7:0]  wr_data_i;
  logic [2:0]  ack_i;
  logic [2:0]  irq_o;
  logic [2:0]  flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pcx_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .xint_i(xint_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .irq_o(irq_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_ack(input logic [2:0] m);
    ack_i = m;
    step();
    ack_i = 3'b000;
  endtask

  task automatic do_reset(input logic [15:0] p, input logic x);
    pin_i = p; xint_i = x; rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1", "flags after reset", flags_o, 3'b000);
    chk("R1", "irq after reset", irq_o, 3'b000);
    step(4);
    chk("R1", "flags settle quiet", flags_o, 3'b000);
  endtask

  task automatic t_reset_with_high_pins;
    do_reset(16'h00FF, 1'b1);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h1F);
    step(4);
    chk("R1", "no flag from pre-reset levels", flags_o, 3'b000);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    pin_i = 16'h0000;
    step(4);
  endtask

  task automatic t_group0;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    pin_i[0] = 1'b1;
    step(2);
    chk("R9", "flag not yet set after two edges", flags_o[1], 1'b0);
    step();
    chk("R9", "flag set on third edge", flags_o[1], 1'b1);
    chk("R2", "rising toggle request", irq_o, 3'b010);
    wr(2'd3, 8'h02);
    chk("R7", "write-one clear", flags_o, 3'b000);
    pin_i[0] = 1'b0;
    step(3);
    chk("R2", "falling toggle flag", flags_o, 3'b010);
    pulse_ack(3'b010);
    chk("R7", "ack clear", flags_o, 3'b000);
  endtask

  task automatic t_group1;
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h80);
    pin_i[15] = 1'b1;
    step(3);
    chk("R3", "pin 15 toggle", flags_o, 3'b100);
    chk("R3", "group 1 request", irq_o, 3'b100);
    wr(2'd3, 8'h04);
    pin_i[8] = 1'b1;
    pin_i[7] = 1'b1;
    step(4);
    chk("R4", "masked pins 8 and 7 ignored", flags_o, 3'b000);
    pin_i[15] = 1'b0;
    step(3);
    chk("R3", "pin 15 falling", flags_o, 3'b100);
    wr(2'd3, 8'h04);
    pin_i[8] = 1'b0;
    pin_i[7] = 1'b0;
    step(4);
  endtask

  task automatic t_mask;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h00);
    pin_i[3] = 1'b1;
    step(4);
    chk("R4", "unmasked-off pin ignored", flags_o[1], 1'b0);
    wr(2'd1, 8'h08);
    step(4);
    chk("R4", "mask set on steady high pin", flags_o[1], 1'b0);
    pin_i[3] = 1'b0;
    step(3);
    chk("R4", "now-masked pin reports", flags_o[1], 1'b1);
    wr(2'd3, 8'h02);
  endtask

  task automatic t_enable;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    pin_i[0] = 1'b1;
    step(3);
    chk("R7", "flag set while disabled", flags_o[1], 1'b1);
    chk("R7", "no request while disabled", irq_o[1], 1'b0);
    wr(2'd0, 8'h08);
    chk("R7", "request after enable", irq_o[1], 1'b1);
    step(6);
    chk("R7", "flag is sticky", flags_o[1], 1'b1);
    pulse_ack(3'b010);
    chk("R7", "request drops after ack", irq_o[1], 1'b0);
  endtask

  task automatic t_set_wins;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    pin_i[0] = 1'b0;
    step(3);
    chk("R8", "setup flag", flags_o[1], 1'b1);
    pin_i[0] = 1'b1;
    step(2);
    pulse_ack(3'b010);
    chk("R8", "event beats ack", flags_o[1], 1'b1);
    pulse_ack(3'b010);
    chk("R8", "ack alone clears", flags_o[1], 1'b0);
    pin_i[0] = 1'b0;
    step(2);
    wr(2'd3, 8'h02);
    chk("R8", "event beats write clear", flags_o[1], 1'b1);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_level;
    xint_i = 1'b1;
    wr(2'd0, 8'h04);
    step(3);
    chk("R5", "no request with pin high", irq_o[0], 1'b0);
    xint_i = 1'b0;
    step(2);
    chk("R5", "level request", irq_o[0], 1'b1);
    step(5);
    chk("R5", "level request held", irq_o[0], 1'b1);
    chk("R5", "no flag in level mode", flags_o[0], 1'b0);
    xint_i = 1'b1;
    step(2);
    chk("R5", "request drops on release", irq_o[0], 1'b0);
    chk("R5", "still no flag", flags_o[0], 1'b0);
  endtask

  task automatic t_edges;
    wr(2'd0, 8'h06);
    xint_i = 1'b0;
    step(3);
    chk("R6", "falling mode, fall", flags_o[0], 1'b1);
    chk("R6", "falling mode request", irq_o[0], 1'b1);
    wr(2'd3, 8'h01);
    xint_i = 1'b1;
    step(4);
    chk("R6", "falling mode, rise ignored", flags_o[0], 1'b0);
    wr(2'd0, 8'h07);
    xint_i = 1'b0;
    step(4);
    chk("R6", "rising mode, fall ignored", flags_o[0], 1'b0);
    xint_i = 1'b1;
    step(3);
    chk("R6", "rising mode, rise", flags_o[0], 1'b1);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h05);
    xint_i = 1'b0;
    step(3);
    chk("R6", "any mode, fall", flags_o[0], 1'b1);
    wr(2'd3, 8'h01);
    xint_i = 1'b1;
    step(3);
    chk("R6", "any mode, rise", flags_o[0], 1'b1);
    wr(2'd3, 8'h01);
    chk("R10", "clear register bit 0", flags_o[0], 1'b0);
  endtask

  initial begin
    ack_i = 3'b000; wr_en_i = 1'b0; wr_addr_i = 2'd0; wr_data_i = 8'h00;
    do_reset(16'h0000, 1'b1);
    t_reset();
    t_group0();
    t_group1();
    t_mask();
    t_enable();
    t_set_wins();
    t_level();
    t_edges();
    t_reset_with_high_pins();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule